// File: doc/BRIEF.md
# Accumulating ALU Datapath

This block is a 16-bit arithmetic and logic datapath built for pipelined and chained calculation. Two operands pass through optional input registers and then through force-to-zero multiplexers. The ALU applies one of eight functions to them. Its output lands in a result register, and that register always feeds back to the B operand path. Each register loads only while its active-low enable is low.

Two bypass controls route data around the input registers or around the result register. The bypassed registers keep loading under their enables. A host can therefore run purely combinational arithmetic while the registers still track the data.

The operand-select lines and the function select cover several uses with no extra control. Selecting the feedback path with new A values accumulates. Forcing B to zero and adding preloads A into the accumulator. The all-zeros function clears the accumulator. The result port is qualified by a drive flag in place of a three-state pad.

Top module: `acc_alu_datapath`

## Requirements
- R1: The function select gives: 0 = all zeros, 4 = A XOR B, 5 = A OR B, 6 = A AND B, 7 = all ones, applied to the selected operands.
- R2: The function select gives: 1 = NOT(A)+B+carry_in, 2 = A+NOT(B)+carry_in, 3 = A+B+carry_in, modulo 2^16. Code 2 with carry_in=1 yields A-B, and code 1 with carry_in=1 yields B-A.
- R3: Operand selection, written as {sel_b_keep, sel_a_keep}, works as follows. 00 gives B operand = result register and A operand = A source. 01 gives B operand = 0 and A operand = A source. 10 gives B operand = B source and A operand = 0. 11 gives B operand = B source and A operand = A source.
- R4: The A and B input registers load on a rising edge only when a_load_n or b_load_n is low, respectively. Otherwise they hold their value.
- R5: With in_bypass=1 the raw a_in and b_in feed the operand multiplexers. The input registers still load under their enables, and their contents are used again once in_bypass returns to 0.
- R6: The result register loads the ALU output on a rising edge when f_load_n is low and holds otherwise. With out_bypass=0 the result port shows the result register.
- R7: With out_bypass=1 the result port shows the ALU output directly, while the result register keeps loading under f_load_n.
- R8: The feedback operand in select mode 00 always comes from the result register, whatever the value of out_bypass.
- R9: zero_flag is 1 exactly when all 16 ALU output bits are 0.
- R10: ovf_flag is the XOR of the carry into bit 15 and the carry out of bit 15 for function codes 1, 2 and 3, and is 0 for all other codes.
- R11: When out_en=0, res_drive is 0 and res_out reads all zeros. When out_en=1, res_drive is 1.
- R12: A synchronous active-high rst clears the A, B and result registers to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | A operand data |
| b_in | input | 16 | B operand data |
| func_sel | input | 3 | ALU function code |
| carry_in | input | 1 | Carry into bit 0 |
| sel_a_keep | input | 1 | Operand select, low bit |
| sel_b_keep | input | 1 | Operand select, high bit |
| a_load_n | input | 1 | A register load enable, active low |
| b_load_n | input | 1 | B register load enable, active low |
| f_load_n | input | 1 | Result register load enable, active low |
| in_bypass | input | 1 | Route raw inputs around the input registers |
| out_bypass | input | 1 | Route ALU output around the result register |
| out_en | input | 1 | Result output enable |
| res_out | output | 16 | Result data, zero when not driven |
| res_drive | output | 1 | High when res_out is driven |
| zero_flag | output | 1 | ALU output is all zeros |
| ovf_flag | output | 1 | Signed overflow of an arithmetic function |

## Verification
A corrupted result register shows up at res_out within one clock whenever out_bypass is low. When out_bypass is high, the same fault surfaces through the ALU output in feedback mode, on the same cycle the feedback path is selected. A stale or wrongly loaded input register only becomes visible after in_bypass drops, so the bench loads registers during bypass and reads them back afterwards. Accumulate chains expose any feedback or load-enable fault as a wrong running sum on the very next edge.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [2:0] {
        FN_CLEAR     = 3'd0,
        FN_NOTA_ADD  = 3'd1,
        FN_ADD_NOTB  = 3'd2,
        FN_ADD       = 3'd3,
        FN_XOR       = 3'd4,
        FN_OR        = 3'd5,
        FN_AND       = 3'd6,
        FN_PRESET    = 3'd7
    } alu_fn_e;

    // {b_keep, a_keep}
    typedef enum logic [1:0] {
        OPS_FEEDBACK = 2'b00,
        OPS_ZERO_B   = 2'b01,
        OPS_ZERO_A   = 2'b10,
        OPS_BOTH     = 2'b11
    } opsel_e;

    typedef struct packed {
        logic zero;
        logic ovf;
    } alu_flags_t;

    function automatic logic fn_is_arith(alu_fn_e fn);
        return (fn == FN_NOTA_ADD) || (fn == FN_ADD_NOTB) || (fn == FN_ADD);
    endfunction

endpackage

// File: rtl/acc_carry_chain.sv
module acc_carry_chain #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_msb,
    output logic         c_out
);
    logic [W:0]   c;
    logic [W-1:0] gen, prop;

    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gen[i]  = x[i] & y[i];
        assign prop[i] = x[i] | y[i];
        assign c[i+1]  = gen[i] | (prop[i] & c[i]);
        assign sum[i]  = x[i] ^ y[i] ^ c[i];
    end

    assign c_msb = c[W-1];
    assign c_out = c[W];
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  alu_fn_e      fn,
    input  logic         cin,
    output logic [W-1:0] f,
    output alu_flags_t   flags
);
    logic [W-1:0] x, y, sum;
    logic         c_msb, c_out;

    always_comb begin
        x = (fn == FN_NOTA_ADD) ? ~op_a : op_a;
        y = (fn == FN_ADD_NOTB) ? ~op_b : op_b;
    end

    acc_carry_chain #(.W(W)) u_chain (
        .x    (x),
        .y    (y),
        .cin  (cin),
        .sum  (sum),
        .c_msb(c_msb),
        .c_out(c_out)
    );

    always_comb begin
        unique case (fn)
            FN_CLEAR:                       f = '0;
            FN_NOTA_ADD, FN_ADD_NOTB, FN_ADD: f = sum;
            FN_XOR:                         f = op_a ^ op_b;
            FN_OR:                          f = op_a | op_b;
            FN_AND:                         f = op_a & op_b;
            FN_PRESET:                      f = '1;
            default:                        f = '0;
        endcase
    end

    always_comb begin
        flags.zero = (f == '0);
        flags.ovf  = fn_is_arith(fn) ? (c_msb ^ c_out) : 1'b0;
    end
endmodule

// File: rtl/acc_operand_stage.sv
module acc_operand_stage
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         a_load_n,
    input  logic         b_load_n,
    input  logic         in_bypass,
    input  opsel_e       opsel,
    input  logic [W-1:0] fb,
    output logic [W-1:0] op_a,
    output logic [W-1:0] op_b
);
    logic [W-1:0] a_reg, b_reg;
    logic [W-1:0] a_src, b_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_reg <= '0;
            b_reg <= '0;
        end else begin
            if (!a_load_n) a_reg <= a_in;
            if (!b_load_n) b_reg <= b_in;
        end
    end

    always_comb begin
        a_src = in_bypass ? a_in : a_reg;
        b_src = in_bypass ? b_in : b_reg;
        unique case (opsel)
            OPS_FEEDBACK: begin op_a = a_src; op_b = fb;    end
            OPS_ZERO_B:   begin op_a = a_src; op_b = '0;    end
            OPS_ZERO_A:   begin op_a = '0;    op_b = b_src; end
            default:      begin op_a = a_src; op_b = b_src; end
        endcase
    end

    // R4
    a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(a_load_n)) |-> (a_reg == $past(a_reg)));

    // R4
    b_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(b_load_n)) |-> (b_reg == $past(b_reg)));

    // R12
    in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (a_reg == '0 && b_reg == '0));
endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [2:0]   func_sel,
    input  logic         carry_in,
    input  logic         sel_a_keep,
    input  logic         sel_b_keep,
    input  logic         a_load_n,
    input  logic         b_load_n,
    input  logic         f_load_n,
    input  logic         in_bypass,
    input  logic         out_bypass,
    input  logic         out_en,
    output logic [W-1:0] res_out,
    output logic         res_drive,
    output logic         zero_flag,
    output logic         ovf_flag
);
    alu_fn_e      fn;
    opsel_e       opsel;
    logic [W-1:0] op_a, op_b, alu_f, f_reg, res_sel;
    alu_flags_t   flags;

    assign fn    = alu_fn_e'(func_sel);
    assign opsel = opsel_e'({sel_b_keep, sel_a_keep});

    acc_operand_stage #(.W(W)) u_operands (
        .clk      (clk),
        .rst      (rst),
        .a_in     (a_in),
        .b_in     (b_in),
        .a_load_n (a_load_n),
        .b_load_n (b_load_n),
        .in_bypass(in_bypass),
        .opsel    (opsel),
        .fb       (f_reg),
        .op_a     (op_a),
        .op_b     (op_b)
    );

    acc_alu_core #(.W(W)) u_core (
        .op_a (op_a),
        .op_b (op_b),
        .fn   (fn),
        .cin  (carry_in),
        .f    (alu_f),
        .flags(flags)
    );

    always_ff @(posedge clk) begin
        if (rst)            f_reg <= '0;
        else if (!f_load_n) f_reg <= alu_f;
    end

    always_comb begin
        res_sel   = out_bypass ? alu_f : f_reg;
        res_drive = out_en;
        res_out   = out_en ? res_sel : '0;
        zero_flag = flags.zero;
        ovf_flag  = flags.ovf;
    end

    // R6
    f_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(f_load_n)) |-> (f_reg == $past(alu_f)));

    // R12
    f_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (f_reg == '0));

    // R8
    feedback_src_chk: assert property (@(posedge clk) disable iff (rst)
        (opsel == OPS_FEEDBACK) |-> (op_b == f_reg));

    // R1
    clear_fn_chk: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_CLEAR) |-> (alu_f == '0));

    // R10
    no_logic_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        !fn_is_arith(fn) |-> !ovf_flag);

    // R9
    zero_port_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_flag && out_en && out_bypass) |-> (res_out == '0));
endmodule

// File: tb/acc_alu_datapath_test.sv
module acc_alu_datapath_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a_in = '0, b_in = '0;
    logic [2:0]  func_sel = '0;
    logic        carry_in = 1'b0;
    logic        sel_a_keep = 1'b1, sel_b_keep = 1'b1;
    logic        a_load_n = 1'b1, b_load_n = 1'b1, f_load_n = 1'b1;
    logic        in_bypass = 1'b0, out_bypass = 1'b0, out_en = 1'b1;
    logic [15:0] res_out;
    logic        res_drive, zero_flag, ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    acc_alu_datapath uut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .func_sel(func_sel),
        .carry_in(carry_in), .sel_a_keep(sel_a_keep), .sel_b_keep(sel_b_keep),
        .a_load_n(a_load_n), .b_load_n(b_load_n), .f_load_n(f_load_n),
        .in_bypass(in_bypass), .out_bypass(out_bypass), .out_en(out_en),
        .res_out(res_out), .res_drive(res_drive), .zero_flag(zero_flag),
        .ovf_flag(ovf_flag)
    );

    // {a, b, func, cin, expected result, zero, ovf}
    localparam logic [53:0] VECS [0:13] = '{
        {16'h1234, 16'h00FF, 3'd0, 1'b0, 16'h0000, 1'b1, 1'b0},
        {16'h1234, 16'h00FF, 3'd7, 1'b0, 16'hFFFF, 1'b0, 1'b0},
        {16'hF0F0, 16'hFF00, 3'd4, 1'b0, 16'h0FF0, 1'b0, 1'b0},
        {16'hF0F0, 16'hFF00, 3'd5, 1'b0, 16'hFFF0, 1'b0, 1'b0},
        {16'hF0F0, 16'hFF00, 3'd6, 1'b0, 16'hF000, 1'b0, 1'b0},
        {16'h0001, 16'h0002, 3'd3, 1'b0, 16'h0003, 1'b0, 1'b0},
        {16'h7FFF, 16'h0001, 3'd3, 1'b0, 16'h8000, 1'b0, 1'b1},
        {16'hFFFF, 16'h0001, 3'd3, 1'b0, 16'h0000, 1'b1, 1'b0},
        {16'h0005, 16'h0003, 3'd2, 1'b1, 16'h0002, 1'b0, 1'b0},
        {16'h0005, 16'h0003, 3'd1, 1'b1, 16'hFFFE, 1'b0, 1'b0},
        {16'h8000, 16'h0001, 3'd2, 1'b1, 16'h7FFF, 1'b0, 1'b1},
        {16'h0003, 16'h0003, 3'd2, 1'b1, 16'h0000, 1'b1, 1'b0},
        {16'h8000, 16'h8000, 3'd3, 1'b0, 16'h0000, 1'b1, 1'b1},
        {16'h0000, 16'h0000, 3'd3, 1'b1, 16'h0001, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // advance one rising edge, settle mid-cycle
    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic set_ops(input logic b_keep, input logic a_keep);
        sel_b_keep = b_keep;
        sel_a_keep = a_keep;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        // reset: R12
        repeat (3) @(posedge clk);
        #5 rst = 1'b0;
        func_sel = 3'd3; set_ops(1'b1, 1'b1);
        a_in = 16'hAAAA; b_in = 16'h5555;
        #1;
        chk("R12 result register after reset", res_out, 16'h0000);
        chk("R12 input registers after reset", {15'd0, zero_flag}, 16'h0001);
        chk("R11 driven", {15'd0, res_drive}, 16'h0001);

        // combinational table, all bypassed: R1 R2 R9 R10
        in_bypass = 1'b1; out_bypass = 1'b1;
        for (int i = 0; i < 14; i++) begin
            {a_in, b_in, func_sel, carry_in} = VECS[i][53:18];
            #2;
            chk($sformatf("R1/R2 vec %0d result", i), res_out, VECS[i][17:2]);
            chk($sformatf("R9 vec %0d zero", i), {15'd0, zero_flag}, {15'd0, VECS[i][1]});
            chk($sformatf("R10 vec %0d ovf", i), {15'd0, ovf_flag}, {15'd0, VECS[i][0]});
        end
        carry_in = 1'b0;

        // R4: load input registers, then hold
        @(negedge clk);
        in_bypass = 1'b0; func_sel = 3'd3;
        a_in = 16'h0011; b_in = 16'h0022; a_load_n = 1'b0; b_load_n = 1'b0;
        tick();
        a_load_n = 1'b1; b_load_n = 1'b1;
        a_in = 16'h7777; b_in = 16'h1000;
        tick();
        chk("R4 registers hold while enables high", res_out, 16'h0033);

        // R5: bypass uses raw inputs, registers still load
        in_bypass = 1'b1; a_in = 16'h0100; b_in = 16'h0200;
        a_load_n = 1'b0; b_load_n = 1'b0;
        #1;
        chk("R5 bypass uses raw inputs", res_out, 16'h0300);
        tick();
        a_load_n = 1'b1; b_load_n = 1'b1;
        in_bypass = 1'b0; a_in = 16'h0F0F; b_in = 16'h0F0F;
        #1;
        chk("R5 registers loaded during bypass", res_out, 16'h0300);

        // R6: result register load and hold
        in_bypass = 1'b1; out_bypass = 1'b0;
        a_in = 16'h0005; b_in = 16'h0007; f_load_n = 1'b0;
        tick();
        chk("R6 result register loads", res_out, 16'h000C);
        f_load_n = 1'b1; a_in = 16'h0001;
        tick();
        chk("R6 result register holds", res_out, 16'h000C);

        // R7: output bypass, register keeps loading
        out_bypass = 1'b1; f_load_n = 1'b0;
        a_in = 16'h0009; b_in = 16'h0001;
        #1;
        chk("R7 bypass shows ALU output", res_out, 16'h000A);
        tick();
        f_load_n = 1'b1; out_bypass = 1'b0;
        #1;
        chk("R7 register loaded during bypass", res_out, 16'h000A);

        // R8 accumulate: preload with B forced zero
        f_load_n = 1'b0; set_ops(1'b0, 1'b1); a_in = 16'h0010; b_in = 16'hFFFF;
        tick();
        chk("R8 preload", res_out, 16'h0010);
        set_ops(1'b0, 1'b0); a_in = 16'h0005;
        tick();
        chk("R8 accumulate step 1", res_out, 16'h0015);
        a_in = 16'h0003;
        tick();
        chk("R8 accumulate step 2", res_out, 16'h0018);
        out_bypass = 1'b1; a_in = 16'h0002;
        #1;
        chk("R8 feedback under out_bypass", res_out, 16'h001A);
        tick();
        chk("R8 feedback from register after load", res_out, 16'h001C);
        func_sel = 3'd0;
        tick();
        out_bypass = 1'b0;
        #1;
        chk("R8 clear accumulator", res_out, 16'h0000);

        // R3 operand selects (result register is zero now)
        f_load_n = 1'b1; out_bypass = 1'b1; func_sel = 3'd3;
        a_in = 16'h1111; b_in = 16'h0200;
        set_ops(1'b1, 1'b0); #1;
        chk("R3 sel 10 forces A to zero", res_out, 16'h0200);
        set_ops(1'b0, 1'b1); #1;
        chk("R3 sel 01 forces B to zero", res_out, 16'h1111);
        set_ops(1'b0, 1'b0); #1;
        chk("R3 sel 00 uses feedback", res_out, 16'h1111);
        set_ops(1'b1, 1'b1); #1;
        chk("R3 sel 11 uses both", res_out, 16'h1311);

        // R11 output enable
        out_en = 1'b0; #1;
        chk("R11 not driven", {15'd0, res_drive}, 16'h0000);
        chk("R11 data zero when off", res_out, 16'h0000);
        out_en = 1'b1; #1;
        chk("R11 driven again", res_out, 16'h1311);

        // R12 reset clears loaded registers
        in_bypass = 1'b0; a_load_n = 1'b0; b_load_n = 1'b0; f_load_n = 1'b0;
        tick();
        a_load_n = 1'b1; b_load_n = 1'b1; f_load_n = 1'b1;
        rst = 1'b1;
        tick();
        rst = 1'b0; out_bypass = 1'b0;
        #1;
        chk("R12 result register cleared", res_out, 16'h0000);
        out_bypass = 1'b1; #1;
        chk("R12 input registers cleared", res_out, 16'h0000);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule